// File: doc/BRIEF.md
# CAN Controller Mode-Control Register

This block holds the 8-bit mode-control register of a CAN controller and the routing logic that the register drives. Software reads it at any time through a simple port. Writes take effect only while the controller sits in initialization, which means both the init request and the init acknowledge inputs are high. A write at any other time is dropped and raises a one-cycle error strobe. Outside special mode, the module-enable bit can be set only once after reset.

The mode bits act directly on the pins. Loopback sends the engine's transmit stream back into its receive input and holds the TX pin recessive. Listen-only blocks transmission and suppresses acknowledge and error signalling, and it freezes the error counters. A wake-up detector watches the RX pin. Depending on the wake-mode bit, it fires on any dominant sample or only after a dominant run of `FILTER_CYCLES` samples.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, `rd_data` reads `{6'b000100, slp_ack, init_ack}`. Listen-only (bit 4) is 1, and all other control bits (7 to 2) are 0.
- R2: A write with `wr_en` high and not both `init_req` and `init_ack` high leaves bits 7 to 2 unchanged. In the next cycle it gives exactly one cycle of `wr_err`.
- R3: With `special_mode` low, only the first accepted write after reset changes bit 7 (enable). Later accepted writes leave bit 7 as it is but still update bits 6 to 2.
- R4: With `special_mode` high, every accepted write updates bit 7.
- R5: The control fields sit at these positions: bit 7 `mod_en`, bit 6 `clk_sel_bus` (0 = oscillator, 1 = bus clock), bit 5 `loop_en`, bit 4 `listen_en`, bit 3 `bo_user` (0 = automatic recovery, 1 = recovery on user request), bit 2 `wk_filt`. Bits 1 and 0 read back `slp_ack` and `init_ack`, and writes to them have no effect.
- R6: With `loop_en` set, `pe_rx` equals `pe_tx`, `can_rx` is ignored, and `can_tx` is 1.
- R7: With neither loopback nor listen-only set, `can_tx` equals `pe_tx` and `pe_rx` equals `can_rx`.
- R8: With `listen_en` set and loopback clear, `can_tx` is 1 and `pe_rx` equals `can_rx`. In this mode `tx_allow` is 0 and `err_freeze` is 1. `ack_ignore` equals `loop_en`.
- R9: With `wake_en` high and `wk_filt` 0, a run of one or more dominant (0) samples on `can_rx` gives exactly one `wake` pulse. With `wake_en` low, no pulse is produced.
- R10: With `wk_filt` 1, a dominant run gives one `wake` pulse only if it lasts at least `FILTER_CYCLES` samples. A recessive sample restarts the count. `wake` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| special_mode | input | 1 | Special system mode; makes the enable bit rewritable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| init_req | input | 1 | Init request from the controller |
| init_ack | input | 1 | Init acknowledge status |
| slp_ack | input | 1 | Sleep acknowledge status |
| wr_err | output | 1 | One-cycle strobe for a dropped write |
| mod_en | output | 1 | Module enable |
| clk_sel_bus | output | 1 | Clock source: 1 = bus clock |
| loop_en | output | 1 | Loopback self test |
| listen_en | output | 1 | Listen-only mode |
| bo_user | output | 1 | Bus-off recovery on user request |
| wk_filt | output | 1 | Wake-up filter select |
| pe_tx | input | 1 | Engine transmit bit |
| pe_rx | output | 1 | Engine receive bit |
| can_tx | output | 1 | TX pin |
| can_rx | input | 1 | RX pin |
| tx_allow | output | 1 | Engine may start transmissions |
| ack_ignore | output | 1 | Ignore the bit sampled in the ACK slot |
| err_freeze | output | 1 | Freeze the error counters |
| wake_en | input | 1 | Wake-up detection enable |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
A corrupted register bit shows up on `rd_data` and on its control output in the cycle right after the write that caused it. The bench sweeps all 256 data values so that every field position is observed. A broken write gate or enable lock appears as a changed bit 7 or as a missing or doubled `wr_err` within one cycle. A wrong wake counter shows up as a pulse one sample early or late, as a missing pulse, or as a second pulse within a dominant run. The pin routing is combinational, so a mux fault shows on `can_tx` or `pe_rx` in the same cycle.

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl #(
  parameter int FILTER_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       special_mode,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       init_req,
  input  logic       init_ack,
  input  logic       slp_ack,
  output logic       wr_err,
  output logic       mod_en,
  output logic       clk_sel_bus,
  output logic       loop_en,
  output logic       listen_en,
  output logic       bo_user,
  output logic       wk_filt,
  input  logic       pe_tx,
  output logic       pe_rx,
  output logic       can_tx,
  input  logic       can_rx,
  output logic       tx_allow,
  output logic       ack_ignore,
  output logic       err_freeze,
  input  logic       wake_en,
  output logic       wake
);
  localparam int CW = $clog2(FILTER_CYCLES + 1);
  localparam logic [CW-1:0] FMAX = CW'(FILTER_CYCLES);
  localparam logic [CW-1:0] FLAST = CW'(FILTER_CYCLES - 1);

  logic          in_init, wr_ok, en_used;
  logic [CW-1:0] dom_cnt, thr_m1;

  assign in_init = init_req & init_ack;
  assign wr_ok   = wr_en & in_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_en      <= 1'b0;
      clk_sel_bus <= 1'b0;
      loop_en     <= 1'b0;
      listen_en   <= 1'b1;
      bo_user     <= 1'b0;
      wk_filt     <= 1'b0;
      en_used     <= 1'b0;
      wr_err      <= 1'b0;
    end else begin
      wr_err <= wr_en & ~in_init;
      if (wr_ok) begin
        if (special_mode || !en_used) mod_en <= wr_data[7];
        en_used     <= 1'b1;
        clk_sel_bus <= wr_data[6];
        loop_en     <= wr_data[5];
        listen_en   <= wr_data[4];
        bo_user     <= wr_data[3];
        wk_filt     <= wr_data[2];
      end
    end
  end

  assign rd_data = {mod_en, clk_sel_bus, loop_en, listen_en, bo_user, wk_filt, slp_ack, init_ack};

  assign can_tx     = (loop_en | listen_en) ? 1'b1 : pe_tx;
  assign pe_rx      = loop_en ? pe_tx : can_rx;
  assign tx_allow   = ~listen_en;
  assign ack_ignore = loop_en;
  assign err_freeze = listen_en;

  assign thr_m1 = wk_filt ? FLAST : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_cnt <= '0;
      wake    <= 1'b0;
    end else begin
      wake <= wake_en & ~can_rx & (dom_cnt == thr_m1);
      if (can_rx)              dom_cnt <= '0;
      else if (dom_cnt != FMAX) dom_cnt <= dom_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       special_mode,
  input logic       wr_en,
  input logic       init_req,
  input logic       init_ack,
  input logic [7:0] rd_data,
  input logic       wr_err,
  input logic       mod_en,
  input logic       loop_en,
  input logic       listen_en,
  input logic       pe_tx,
  input logic       pe_rx,
  input logic       can_tx,
  input logic       wake
);
  // R2
  dropped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(init_req && init_ack)) |=> ($stable(rd_data[7:2]) && wr_err));
  // R3
  enable_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !special_mode) |=> mod_en);
  // R6
  loop_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (can_tx && pe_rx == pe_tx));
  // R8
  listen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    listen_en |-> can_tx);
  // R10
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
endmodule

bind can_mode_ctrl can_mode_ctrl_chk chk (
  .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .wr_en(wr_en),
  .init_req(init_req), .init_ack(init_ack), .rd_data(rd_data), .wr_err(wr_err),
  .mod_en(mod_en), .loop_en(loop_en), .listen_en(listen_en), .pe_tx(pe_tx),
  .pe_rx(pe_rx), .can_tx(can_tx), .wake(wake)
);

// File: tb/tb_can_mode_ctrl.sv
module tb_can_mode_ctrl;
  localparam int FC = 4;
  logic clk = 0, rst_n = 0;
  logic special_mode = 0, wr_en = 0, init_req = 0, init_ack = 1, slp_ack = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic wr_err, mod_en, clk_sel_bus, loop_en, listen_en, bo_user, wk_filt;
  logic pe_tx = 1, pe_rx, can_tx, can_rx = 1, tx_allow, ack_ignore, err_freeze;
  logic wake_en = 0, wake;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  can_mode_ctrl #(.FILTER_CYCLES(FC)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic gate);
    @(negedge clk);
    init_req = gate; wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wake_run(input int len, input int exp_pulses, input string tag);
    int n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk); n += wake; can_rx = 0;
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); n += wake; can_rx = 1;
    end
    chk(n == exp_pulses, tag, n, exp_pulses);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] cur;
    logic en_exp;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(rd_data == 8'h11, "R1 reset", rd_data, 8'h11);
    slp_ack = 1; init_ack = 0; #1;
    chk(rd_data == 8'h12, "R1 status bits", rd_data, 8'h12);
    slp_ack = 0; init_ack = 1;

    // R2: dropped writes with each non-init gate combination
    for (int g = 0; g < 3; g++) begin
      @(negedge clk);
      init_req = g[0]; init_ack = g[1]; wr_en = 1; wr_data = 8'hFC;
      @(negedge clk);
      wr_en = 0;
      chk(rd_data[7:2] == 6'b000100, "R2 dropped", rd_data, 8'h10);
      chk(wr_err == 1, "R2 err strobe", wr_err, 1);
      @(negedge clk);
      chk(wr_err == 0, "R2 strobe width", wr_err, 0);
    end
    init_ack = 1;

    // R3: enable write-once in normal mode
    wr(8'hFF, 1);
    chk(rd_data == 8'hFD, "R3 first write", rd_data, 8'hFD);
    chk(wr_err == 0, "R3 no err", wr_err, 0);
    wr(8'h00, 1);
    chk(rd_data == 8'h81, "R3 enable locked", rd_data, 8'h81);
    wr(8'h68, 1);
    chk(rd_data == 8'hE9, "R3 other bits", rd_data, 8'hE9);

    // R4 + R5: full data sweep in special mode
    special_mode = 1;
    for (int d = 0; d < 256; d++) begin
      wr(8'(d), 1);
      cur = 8'(d);
      chk(rd_data == {cur[7:2], 2'b01}, "R4 R5 readback", rd_data, {cur[7:2], 2'b01});
      chk({mod_en, clk_sel_bus, loop_en, listen_en, bo_user, wk_filt} == cur[7:2],
          "R5 field outputs", {mod_en, clk_sel_bus, loop_en, listen_en, bo_user, wk_filt}, cur[7:2]);
    end

    // R3 again after reset, sweep: enable follows only first write
    special_mode = 0;
    rst_n = 0; @(negedge clk); rst_n = 1;
    for (int d = 0; d < 256; d += 37) begin
      cur = 8'(d);
      if (d == 0) en_exp = cur[7];
      wr(cur, 1);
      chk(rd_data[7] == en_exp, "R3 lock sweep", rd_data[7], en_exp);
    end

    // R6 R7 R8: routing for each mode and input combination
    special_mode = 1;
    for (int m = 0; m < 4; m++) begin
      wr({2'b00, m[1], m[0], 4'b0000}, 1);
      for (int v = 0; v < 4; v++) begin
        pe_tx = v[0]; can_rx = v[1]; #1;
        if (m[1]) begin
          chk(can_tx == 1, "R6 tx recessive", can_tx, 1);
          chk(pe_rx == v[0], "R6 loop rx", pe_rx, v[0]);
        end else if (m[0]) begin
          chk(can_tx == 1, "R8 listen tx", can_tx, 1);
          chk(pe_rx == v[1], "R8 listen rx", pe_rx, v[1]);
        end else begin
          chk(can_tx == v[0], "R7 tx", can_tx, v[0]);
          chk(pe_rx == v[1], "R7 rx", pe_rx, v[1]);
        end
      end
      chk(tx_allow == !m[0] && err_freeze == m[0] && ack_ignore == m[1], "R8 controls",
          {tx_allow, err_freeze, ack_ignore}, {!m[0], m[0], m[1]});
    end
    can_rx = 1; pe_tx = 1;

    // R9: unfiltered wake
    wr(8'h00, 1);
    wake_run(3, 0, "R9 disabled");
    wake_en = 1;
    wake_run(1, 1, "R9 single sample");
    wake_run(6, 1, "R9 long run");

    // R10: filtered wake
    wr(8'h04, 1);
    for (int len = 1; len <= 2 * FC; len++)
      wake_run(len, (len >= FC) ? 1 : 0, "R10 filter length");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule